// File: doc/BRIEF.md
# Quad-Bank Dual-Port Result Memory

This block is the result and operand store of a four-chain convolution accelerator. It is built from four 32-bit dual-port RAM banks that sit side by side to give a 128-bit row. Each chain owns one bank, so the chains never contend for storage. Port A of a bank belongs to its chain. In one cycle that chain can store a result and fetch an accumulate operand. When both use the same row, the fetch returns the contents from before the write.

Port B of all four banks is steered as one unit by a mode register. In loader mode, the matrix loader reads a whole 128-bit row. In bus mode, a single-cycle slave reaches any single 32-bit word, so the system can fill operands or drain results. The mode may change only while the accelerator reports idle. A change requested while the accelerator is busy is dropped and leaves a sticky error flag. All reads have one cycle of latency.

Top module: `quad_result_mem`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pb_mode` is 0 (loader), `mode_err` is 0, and `a_rdata`, `ld_rdata` and `bus_rdata` are all zero.
- R2: A port-A read on lane i (`a_re[i]`, row at `a_addr[i*AW +: AW]`) returns that bank's word on `a_rdata[i*32 +: 32]` one cycle later. Each of the four lanes works independently in the same cycle.
- R3: When a lane raises `a_we` and `a_re` together, the read returns the word held before the write. A later read of that row returns the new word.
- R4: In loader mode (`pb_mode`=0), `ld_re` with row `ld_row` returns the four banks' words for that row on `ld_rdata` one cycle later, with lane i at bits [32i+31:32i].
- R5: In bus mode (`pb_mode`=1), bits [1:0] of `bus_addr` pick the lane and the upper bits pick the row. `bus_en` with `bus_we`=1 writes `bus_wdata` to that word. `bus_en` with `bus_we`=0 returns that word on `bus_rdata` one cycle later.
- R6: Port A and the bus share the same storage. A word written through either one reads back through the other.
- R7: In loader mode, bus writes change no stored word. In bus mode, `ld_re` leaves `ld_rdata` unchanged.
- R8: `cfg_wr` while `idle`=1 loads `cfg_mode` into `pb_mode`. The new mode governs port B from the next cycle on.
- R9: `cfg_wr` while `idle`=0 leaves `pb_mode` unchanged and sets `mode_err`. `mode_err` then stays at 1 until reset.
- R10: A lane's `a_rdata` holds its value in every cycle in which that lane's `a_re` is low, including cycles with a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle | input | 1 | Accelerator idle; gates mode changes |
| cfg_wr | input | 1 | Request to load the port-B mode |
| cfg_mode | input | 1 | Requested mode: 0 loader, 1 bus |
| pb_mode | output | 1 | Current port-B mode |
| mode_err | output | 1 | Sticky flag: mode change tried while busy |
| a_we | input | 4 | Per-lane result write enable |
| a_re | input | 4 | Per-lane accumulate-operand read enable |
| a_addr | input | 24 | Per-lane row address, 6 bits per lane |
| a_wdata | input | 128 | Per-lane result data, 32 bits per lane |
| a_rdata | output | 128 | Per-lane operand read data |
| ld_re | input | 1 | Loader row read request |
| ld_row | input | 6 | Loader row address |
| ld_rdata | output | 128 | Loader row data, lane i at bits 32i and up |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write (1) or read (0) |
| bus_addr | input | 8 | Bus word address: [1:0] lane, [7:2] row |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data |

## Verification
Port A is first driven with directed accesses. It then runs through several hundred random cycles, in which every lane independently writes, reads or does both within a narrow band of rows. Same-row collisions are common there, so any mix-up between read-first and write-first behaviour shows up. Lanes are also addressed at distinct rows in the same cycle, which separates lane crosstalk from independent operation. Random bus traffic with lane and row drawn separately checks the address split. Cross-port reads tell shared storage apart from private copies. Mode requests are issued with idle both high and low, and bus and loader strobes are issued in the wrong mode, so that a correct guard can be told apart from one that is missing.

// File: rtl/qbm_pkg.sv
package qbm_pkg;
  typedef enum logic {
    PB_LOADER = 1'b0,
    PB_BUS    = 1'b1
  } pb_mode_e;
endpackage

// File: rtl/qbm_bank.sv
module qbm_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] a_q, b_q;

  // storage array, both ports in one process; reads see pre-write contents
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_re) a_q <= mem[a_addr];
      if (b_re) b_q <= mem[b_addr];
    end
  end

  assign a_rdata = a_q;
  assign b_rdata = b_q;

  AST_A_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !a_re |=> $stable(a_rdata)); // R10
endmodule

// File: rtl/qbm_mode_ctl.sv
module qbm_mode_ctl
  import qbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     idle,
  input  logic     cfg_wr,
  input  logic     cfg_mode,
  output pb_mode_e mode_q,
  output logic     err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PB_LOADER;
      err_q  <= 1'b0;
    end else if (cfg_wr) begin
      if (idle) mode_q <= pb_mode_e'(cfg_mode);
      else      err_q  <= 1'b1;
    end
  end

  AST_MODE_TAKE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && idle) |=> (mode_q == pb_mode_e'($past(cfg_mode)))); // R8
  AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !idle) |=> $stable(mode_q)); // R9
  AST_ERR_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !idle) |=> err_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R9
endmodule

// File: rtl/qbm_portb_route.sv
module qbm_portb_route
  import qbm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int AW    = 6,
  localparam int SW   = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  pb_mode_e           mode,
  input  logic               ld_re,
  input  logic [AW-1:0]      ld_row,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [AW+SW-1:0]   bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [LANES-1:0]   b_we,
  output logic [LANES-1:0]   b_re,
  output logic [AW-1:0]      b_addr,
  output logic [DW-1:0]      b_wdata,
  input  logic [LANES*DW-1:0] bank_q,
  output logic [LANES*DW-1:0] ld_rdata,
  output logic [DW-1:0]      bus_rdata
);
  logic          bus_mode;
  logic [SW-1:0] lane_sel;
  logic [SW-1:0] sel_q;
  logic          bus_rd, bus_wr;

  assign bus_mode = (mode == PB_BUS);
  assign lane_sel = bus_addr[SW-1:0];
  assign bus_rd   = bus_mode && bus_en && !bus_we;
  assign bus_wr   = bus_mode && bus_en && bus_we;
  assign b_addr   = bus_mode ? bus_addr[AW+SW-1:SW] : ld_row;
  assign b_wdata  = bus_wdata;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign b_we[i] = bus_wr && (lane_sel == SW'(i));
    assign b_re[i] = bus_mode ? (bus_rd && (lane_sel == SW'(i))) : ld_re;
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (bus_rd) sel_q <= lane_sel;
  end

  assign ld_rdata  = bank_q;
  assign bus_rdata = bank_q[sel_q*DW +: DW];

  AST_BUS_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(b_we)); // R5
  AST_BUS_RE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    bus_mode |-> $onehot0(b_re)); // R5
endmodule

// File: rtl/quad_result_mem.sv
module quad_result_mem
  import qbm_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(LANES),
  localparam int BAW  = AW + SW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle,
  input  logic                cfg_wr,
  input  logic                cfg_mode,
  output logic                pb_mode,
  output logic                mode_err,
  input  logic [LANES-1:0]    a_we,
  input  logic [LANES-1:0]    a_re,
  input  logic [LANES*AW-1:0] a_addr,
  input  logic [LANES*DW-1:0] a_wdata,
  output logic [LANES*DW-1:0] a_rdata,
  input  logic                ld_re,
  input  logic [AW-1:0]       ld_row,
  output logic [LANES*DW-1:0] ld_rdata,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [BAW-1:0]      bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata
);
  pb_mode_e            mode_q;
  logic [LANES-1:0]    b_we, b_re;
  logic [AW-1:0]       b_addr;
  logic [DW-1:0]       b_wdata;
  logic [LANES*DW-1:0] bank_q;

  qbm_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .idle     (idle),
    .cfg_wr   (cfg_wr),
    .cfg_mode (cfg_mode),
    .mode_q   (mode_q),
    .err_q    (mode_err)
  );

  qbm_portb_route #(.LANES(LANES), .DW(DW), .AW(AW)) u_route (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .ld_re     (ld_re),
    .ld_row    (ld_row),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .b_we      (b_we),
    .b_re      (b_re),
    .b_addr    (b_addr),
    .b_wdata   (b_wdata),
    .bank_q    (bank_q),
    .ld_rdata  (ld_rdata),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    qbm_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .a_we    (a_we[i]),
      .a_re    (a_re[i]),
      .a_addr  (a_addr[i*AW +: AW]),
      .a_wdata (a_wdata[i*DW +: DW]),
      .a_rdata (a_rdata[i*DW +: DW]),
      .b_we    (b_we[i]),
      .b_re    (b_re[i]),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .b_rdata (bank_q[i*DW +: DW])
    );
  end

  assign pb_mode = mode_q;

  AST_LD_IGNORED_IN_BUS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PB_BUS && !bus_en) |=> $stable(ld_rdata)); // R7
  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (!mode_err && pb_mode == 1'b0)); // R1
endmodule

// File: tb/quad_result_mem_tb_top.sv
module quad_result_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LN  = 4;
  localparam int DW  = 32;
  localparam int DEP = 64;
  localparam int AW  = 6;

  logic            clk = 1'b0;
  logic            rst;
  logic            idle, cfg_wr, cfg_mode;
  logic            pb_mode, mode_err;
  logic [LN-1:0]   a_we, a_re;
  logic [LN*AW-1:0] a_addr;
  logic [LN*DW-1:0] a_wdata, a_rdata;
  logic            ld_re;
  logic [AW-1:0]   ld_row;
  logic [LN*DW-1:0] ld_rdata;
  logic            bus_en, bus_we;
  logic [AW+1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata, bus_rdata;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] model [LN][DEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_result_mem dut_i (
    .clk(clk), .rst(rst), .idle(idle), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .pb_mode(pb_mode), .mode_err(mode_err),
    .a_we(a_we), .a_re(a_re), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .ld_re(ld_re), .ld_row(ld_row), .ld_rdata(ld_rdata),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] row_of(input int r);
    return {model[3][r], model[2][r], model[1][r], model[0][r]};
  endfunction

  function automatic logic [DW-1:0] fill_val(input int l, input int r);
    return 32'hA000_0000 ^ (l << 16) ^ (r * 32'h0101);
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic quiet();
    cfg_wr = 0; a_we = '0; a_re = '0; ld_re = 0; bus_en = 0; bus_we = 0;
  endtask

  task automatic a_set(input int l, input logic we, input logic re,
                       input int r, input logic [DW-1:0] d);
    a_we[l] = we;
    a_re[l] = re;
    a_addr[l*AW +: AW] = AW'(r);
    a_wdata[l*DW +: DW] = d;
  endtask

  task automatic bus_op(input logic we, input int lane, input int r, input logic [DW-1:0] d);
    bus_en = 1; bus_we = we;
    bus_addr = {AW'(r), 2'(lane)};
    bus_wdata = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] held;
    logic [DW-1:0] exp_l [LN];
    logic          rd_l  [LN];
    void'($urandom(32'd4711));
    rst = 1; idle = 1; cfg_mode = 0; a_addr = '0; a_wdata = '0;
    ld_row = '0; bus_addr = '0; bus_wdata = '0;
    quiet();
    step(); step();
    // R1 during reset
    chk("R1 mode", 128'(pb_mode), 128'(0));
    chk("R1 err", 128'(mode_err), 128'(0));
    rst = 0;
    step();
    chk("R1 a_rdata", a_rdata, 128'(0));
    chk("R1 ld_rdata", ld_rdata, 128'(0));
    chk("R1 bus_rdata", 128'(bus_rdata), 128'(0));

    // fill every row through port A
    for (int r = 0; r < DEP; r++) begin
      for (int l = 0; l < LN; l++) begin
        a_set(l, 1, 0, r, fill_val(l, r));
        model[l][r] = fill_val(l, r);
      end
      step();
    end
    quiet();

    // R2 directed: distinct rows per lane in one cycle
    for (int l = 0; l < LN; l++) a_set(l, 0, 1, 10 + 7*l, 0);
    step();
    quiet();
    for (int l = 0; l < LN; l++)
      chk("R2 lane read", 128'(a_rdata[l*DW +: DW]), 128'(model[l][10 + 7*l]));

    // R3 directed: same-row write and read on lane 2
    a_set(2, 1, 1, 5, 32'hDEAD_BEEF);
    step();
    quiet();
    chk("R3 old data", 128'(a_rdata[2*DW +: DW]), 128'(model[2][5]));
    model[2][5] = 32'hDEAD_BEEF;
    a_set(2, 0, 1, 5, 0);
    step();
    quiet();
    chk("R3 new data", 128'(a_rdata[2*DW +: DW]), 128'(32'hDEAD_BEEF));

    // R10: write only, read data holds
    held = a_rdata;
    a_set(2, 1, 0, 6, 32'h1234_5678);
    model[2][6] = 32'h1234_5678;
    step();
    quiet();
    chk("R10 hold", a_rdata, held);

    // random port A traffic with frequent same-row collisions (R2, R3, R10)
    for (int it = 0; it < 400; it++) begin
      held = a_rdata;
      for (int l = 0; l < LN; l++) begin
        int r;
        logic we, re;
        logic [DW-1:0] d;
        r  = int'($urandom_range(0, 7));
        we = 1'($urandom_range(0, 1));
        re = 1'($urandom_range(0, 1));
        d  = $urandom;
        a_set(l, we, re, r, d);
        rd_l[l]  = re;
        exp_l[l] = re ? model[l][r] : held[l*DW +: DW];
        if (we) model[l][r] = d;
      end
      step();
      for (int l = 0; l < LN; l++)
        chk(rd_l[l] ? "R3 random read" : "R10 random hold",
            128'(a_rdata[l*DW +: DW]), 128'(exp_l[l]));
    end
    quiet();

    // R4 loader row read
    ld_re = 1; ld_row = 9;
    step();
    quiet();
    chk("R4 loader row", ld_rdata, row_of(9));

    // R7: bus write ignored in loader mode
    bus_op(1, 1, 9, 32'hBAD0_BAD0);
    step();
    quiet();
    ld_re = 1; ld_row = 9;
    step();
    quiet();
    chk("R7 bus write ignored", ld_rdata, row_of(9));

    // R9: change while busy is dropped
    idle = 0; cfg_wr = 1; cfg_mode = 1;
    step();
    quiet();
    chk("R9 mode kept", 128'(pb_mode), 128'(0));
    chk("R9 err set", 128'(mode_err), 128'(1));

    // R8: change while idle is taken
    idle = 1; cfg_wr = 1; cfg_mode = 1;
    step();
    quiet();
    chk("R8 mode taken", 128'(pb_mode), 128'(1));

    // R5 directed bus write then read
    bus_op(1, 3, 20, 32'hCAFE_0003);
    model[3][20] = 32'hCAFE_0003;
    step();
    bus_op(0, 3, 20, 0);
    step();
    quiet();
    chk("R5 bus read", 128'(bus_rdata), 128'(32'hCAFE_0003));

    // R6: bus-written word seen on port A, port-A word seen on bus
    a_set(3, 0, 1, 20, 0);
    step();
    quiet();
    chk("R6 bus to A", 128'(a_rdata[3*DW +: DW]), 128'(32'hCAFE_0003));
    a_set(0, 1, 0, 33, 32'h0BAD_F00D);
    model[0][33] = 32'h0BAD_F00D;
    step();
    quiet();
    bus_op(0, 0, 33, 0);
    step();
    quiet();
    chk("R6 A to bus", 128'(bus_rdata), 128'(32'h0BAD_F00D));

    // R7: loader read ignored in bus mode
    held = ld_rdata;
    ld_re = 1; ld_row = 40;
    step();
    quiet();
    chk("R7 loader ignored", ld_rdata, held);

    // random bus traffic (R5)
    for (int it = 0; it < 200; it++) begin
      int r, lane;
      logic we;
      logic [DW-1:0] d, e;
      r    = int'($urandom_range(0, DEP-1));
      lane = int'($urandom_range(0, LN-1));
      we   = 1'($urandom_range(0, 1));
      d    = $urandom;
      e    = model[lane][r];
      bus_op(we, lane, r, d);
      if (we) model[lane][r] = d;
      step();
      quiet();
      if (!we) chk("R5 random bus read", 128'(bus_rdata), 128'(e));
    end

    // R9: flag stays set across a later accepted change
    idle = 1; cfg_wr = 1; cfg_mode = 0;
    step();
    quiet();
    chk("R8 back to loader", 128'(pb_mode), 128'(0));
    chk("R9 err sticky", 128'(mode_err), 128'(1));
    ld_re = 1; ld_row = 20;
    step();
    quiet();
    chk("R4 loader after bus", ld_rdata, row_of(20));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule